// File: doc/BRIEF.md
# Extended-Precision Add/Subtract Condition-Code Unit

This block adds or subtracts two 32-bit operands and keeps a five-bit condition-code state beside the result: extend (X), negative (N), zero (Z), overflow (V) and carry/borrow (C). It works at byte, word or long operand size. A byte or word operation writes only the low part of the result and passes the upper bits of the first operand through, the way a destination register would be partly updated.

Two of the four operations are extend forms. They take the stored X bit as a carry or borrow input. They also keep Z sticky, so a long add or subtract can be split into 32-bit pieces. To run such a chain, start with a plain operation on the least significant word, then issue extend operations on the higher words. After the last word, C, X and Z describe the whole wide value.

The arithmetic is combinational. The result and the flags are registered and change only on a cycle with `in_valid` high.

Top module: `asf_flag_unit`

## Requirements
- R1: With `rst` high at a clock edge, the result register and the flag register become zero. The flag bus is ordered `cc_flags[4]`=X, `[3]`=N, `[2]`=Z, `[1]`=V, `[0]`=C.
- R2: On a clock edge with `in_valid` low, the result and the flags keep their values, whatever the other inputs are.
- R3: `op_sel` selects 0 = add, 1 = subtract, 2 = add with extend, 3 = subtract with extend. `size_sel` selects 0 = byte, 1 = word, 2 or 3 = long. The registered result holds op_a+op_b, op_a−op_b, op_a+op_b+X or op_a−op_b−X at the selected size, modulo 2^size, and takes the upper bits from `op_a`. It appears one clock edge after the operation is presented.
- R4: N is the most significant bit of the result at the selected size.
- R5: For plain add and subtract, Z is set exactly when the result at the selected size is zero.
- R6: For additions, C is set when the masked result is below the masked `op_b`. For an add with extend where X was set, C is set when the masked result is less than or equal to the masked `op_b`.
- R7: For subtractions, C is set when masked `op_a` is below masked `op_b` (unsigned). For a subtract with extend where X was set, C is set when masked `op_a` is less than or equal to masked `op_b`.
- R8: For an addition, V is set when both operands have the same sign at the selected size and the result sign differs from it. For a subtraction, V is set when the operand signs differ and the result sign differs from the sign of `op_a`.
- R9: After every accepted operation, X holds the same value as C.
- R10: For extend operations, the new Z is the previous Z ANDed with the zero test of this result. A nonzero piece clears Z, and a zero piece never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe; the registers update only when this is high |
| op_sel | input | 2 | Operation code (see R3) |
| size_sel | input | 2 | Operand size code (see R3) |
| op_a | input | 32 | First operand (augend or minuend); source of the untouched upper bits |
| op_b | input | 32 | Second operand (addend or subtrahend) |
| result | output | 32 | Registered result |
| cc_flags | output | 5 | Registered condition codes {X,N,Z,V,C} |

## Verification
The bench builds the block with its default lane width of 8 bits. This yields 8-, 16- and 32-bit sizes, and with those sizes the reference model can compute every flag in 64-bit integer arithmetic. At these widths the byte and word cases that sit on a sign or carry boundary can be reached directly: 0x7F+1, 0x80−1, 0x7FFF+1 and 0xFFFFFFFF+1. Three-word chains of extend operations are compared against 96-bit sums and differences, and this covers propagation of the sticky Z and of X across words.

// File: rtl/asf_pkg.sv
package asf_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_ADDX = 2'd2,
    OP_SUBX = 2'd3
  } asf_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } asf_lane_t;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } asf_cc_t;

  localparam int unsigned ASF_LANES = 3;

  // size code -> lane index: 0 byte, 1 word, 2 and 3 long
  function automatic logic [1:0] size_to_lane(input logic [1:0] code);
    return (code[1]) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/asf_lane.sv
module asf_lane
  import asf_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          is_sub,
  input  logic          cin,
  output logic [LW-1:0] r,
  output asf_lane_t     fl
);
  localparam int unsigned MSB = LW - 1;

  logic [LW:0] wide;
  logic [LW:0] cin_w;

  assign cin_w = {{LW{1'b0}}, cin};

  always_comb begin
    if (is_sub) wide = {1'b0, a} - {1'b0, b} - cin_w;
    else        wide = {1'b0, a} + {1'b0, b} + cin_w;
  end

  assign r    = wide[LW-1:0];
  assign fl.n = wide[MSB];
  assign fl.z = ~|wide[LW-1:0];
  assign fl.c = wide[LW];
  assign fl.v = is_sub ? ((a[MSB] ^ b[MSB]) & (wide[MSB] ^ a[MSB]))
                       : (~(a[MSB] ^ b[MSB]) & (wide[MSB] ^ a[MSB]));
endmodule

// File: rtl/asf_size_sel.sv
module asf_size_sel
  import asf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LONG_W = 4 * BYTE_W
) (
  input  logic [1:0]                             size_sel,
  input  logic [LONG_W-1:0]                      pass_hi,
  input  logic [ASF_LANES-1:0][LONG_W-1:0]       lane_r,
  input  asf_lane_t [ASF_LANES-1:0]              lane_fl,
  output logic [LONG_W-1:0]                      merged_r,
  output asf_lane_t                              sel_fl
);
  logic [1:0]                       idx;
  logic [ASF_LANES-1:0][LONG_W-1:0] merged;

  assign idx = size_to_lane(size_sel);

  for (genvar i = 0; i < ASF_LANES; i++) begin : g_merge
    localparam int unsigned LW = BYTE_W << i;
    if (LW < LONG_W) begin : g_part
      assign merged[i] = {pass_hi[LONG_W-1:LW], lane_r[i][LW-1:0]};
    end else begin : g_full
      assign merged[i] = lane_r[i];
    end
  end

  assign merged_r = merged[idx];
  assign sel_fl   = lane_fl[idx];
endmodule

// File: rtl/asf_ccr.sv
module asf_ccr
  import asf_pkg::*;
#(
  parameter int unsigned LONG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              is_ext,
  input  asf_lane_t         nxt_fl,
  input  logic [LONG_W-1:0] nxt_r,
  output asf_cc_t           cc_q,
  output logic [LONG_W-1:0] r_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= '0;
      r_q  <= '0;
    end else if (load) begin
      r_q    <= nxt_r;
      cc_q.x <= nxt_fl.c;
      cc_q.c <= nxt_fl.c;
      cc_q.n <= nxt_fl.n;
      cc_q.v <= nxt_fl.v;
      cc_q.z <= is_ext ? (nxt_fl.z & cc_q.z) : nxt_fl.z;
    end
  end
endmodule

// File: rtl/asf_flag_unit.sv
module asf_flag_unit
  import asf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LONG_W = 4 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [1:0]        size_sel,
  input  logic [LONG_W-1:0] op_a,
  input  logic [LONG_W-1:0] op_b,
  output logic [LONG_W-1:0] result,
  output logic [4:0]        cc_flags
);
  asf_op_e                          op;
  logic                             is_sub;
  logic                             is_ext;
  logic                             carry_in;
  asf_cc_t                          cc_q;
  logic [ASF_LANES-1:0][LONG_W-1:0] lane_r;
  asf_lane_t [ASF_LANES-1:0]        lane_fl;
  logic [LONG_W-1:0]                merged_r;
  asf_lane_t                        sel_fl;

  assign op       = asf_op_e'(op_sel);
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBX);
  assign is_ext   = (op == OP_ADDX) || (op == OP_SUBX);
  assign carry_in = is_ext & cc_q.x;

  for (genvar i = 0; i < ASF_LANES; i++) begin : g_lane
    localparam int unsigned LW = BYTE_W << i;
    logic [LW-1:0] r_i;
    asf_lane #(.LW(LW)) u_lane (
      .a      (op_a[LW-1:0]),
      .b      (op_b[LW-1:0]),
      .is_sub (is_sub),
      .cin    (carry_in),
      .r      (r_i),
      .fl     (lane_fl[i])
    );
    if (LW < LONG_W) begin : g_pad
      assign lane_r[i] = {{(LONG_W-LW){1'b0}}, r_i};
    end else begin : g_nopad
      assign lane_r[i] = r_i;
    end
  end

  asf_size_sel #(.BYTE_W(BYTE_W)) u_sel (
    .size_sel (size_sel),
    .pass_hi  (op_a),
    .lane_r   (lane_r),
    .lane_fl  (lane_fl),
    .merged_r (merged_r),
    .sel_fl   (sel_fl)
  );

  asf_ccr #(.LONG_W(LONG_W)) u_ccr (
    .clk    (clk),
    .rst    (rst),
    .load   (in_valid),
    .is_ext (is_ext),
    .nxt_fl (sel_fl),
    .nxt_r  (merged_r),
    .cc_q   (cc_q),
    .r_q    (result)
  );

  assign cc_flags = cc_q;
endmodule

// File: rtl/asf_flag_unit_chk.sv
module asf_flag_unit_chk #(
  parameter int unsigned LONG_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op_sel,
  input logic [1:0]        size_sel,
  input logic [LONG_W-1:0] op_a,
  input logic [LONG_W-1:0] op_b,
  input logic [LONG_W-1:0] result,
  input logic [4:0]        cc_flags
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cc_flags == 5'd0 && result == '0));

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(cc_flags) && $stable(result)));

  // R9
  a_r9_x_tracks_c: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (cc_flags[4] == cc_flags[0]));

  // R10
  a_r10_sticky_z: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel[1] && !cc_flags[2]) |=> !cc_flags[2]);

  // R8
  a_r8_no_add_overflow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'd0 && size_sel[1] &&
     (op_a[LONG_W-1] != op_b[LONG_W-1])) |=> !cc_flags[1]);

  // R5
  a_r5_zero_not_negative: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !(cc_flags[2] && cc_flags[3]));
endmodule

bind asf_flag_unit asf_flag_unit_chk #(.LONG_W(LONG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_sel   (op_sel),
  .size_sel (size_sel),
  .op_a     (op_a),
  .op_b     (op_b),
  .result   (result),
  .cc_flags (cc_flags)
);

// File: tb/asf_flag_unit_bench.sv
module asf_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [1:0]  size_sel = 2'd2;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [31:0] result;
  logic [4:0]  cc_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          m_x, m_n, m_z, m_v, m_c;
  logic [31:0] m_res;

  always #2 clk = ~clk;

  asf_flag_unit u_asf_flag_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .size_sel(size_sel), .op_a(op_a), .op_b(op_b),
    .result(result), .cc_flags(cc_flags)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input bit [1:0] op, input bit [1:0] sz, input bit [31:0] a, input bit [31:0] b);
    int w;
    longint unsigned m, am, bm, r;
    bit cin, sub, sa, sb, sr;
    w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m   = (64'd1 << w) - 1;
    sub = op[0];
    cin = op[1] & m_x;
    am  = {32'd0, a} & m;
    bm  = {32'd0, b} & m;
    if (!sub) begin
      r   = (am + bm + cin) & m;
      m_c = cin ? (r <= bm) : (r < bm);
    end else begin
      r   = (am - bm - cin) & m;
      m_c = cin ? (am <= bm) : (am < bm);
    end
    sa  = am[w-1];
    sb  = bm[w-1];
    sr  = r[w-1];
    m_n = sr;
    m_v = sub ? (sa != sb && sr != sa) : (sa == sb && sr != sa);
    m_z = op[1] ? ((r == 0) && m_z) : (r == 0);
    m_x = m_c;
    m_res = (a & ~m[31:0]) | r[31:0];
  endtask

  task automatic compare_all(input bit [1:0] op, input bit vld);
    string rr, rn, rz, rc, rv, rx;
    rr = vld ? "R3" : "R2";
    rn = vld ? "R4" : "R2";
    rz = !vld ? "R2" : (op[1] ? "R10" : "R5");
    rc = !vld ? "R2" : (op[0] ? "R7" : "R6");
    rv = vld ? "R8" : "R2";
    rx = vld ? "R9" : "R2";
    chk(result == m_res, rr, result, m_res);
    chk(cc_flags[3] == m_n, rn, cc_flags[3], m_n);
    chk(cc_flags[2] == m_z, rz, cc_flags[2], m_z);
    chk(cc_flags[1] == m_v, rv, cc_flags[1], m_v);
    chk(cc_flags[0] == m_c, rc, cc_flags[0], m_c);
    chk(cc_flags[4] == m_x, rx, cc_flags[4], m_x);
  endtask

  task automatic step(input bit vld, input bit [1:0] op, input bit [1:0] sz,
                      input bit [31:0] a, input bit [31:0] b);
    @(negedge clk);
    in_valid = vld; op_sel = op; size_sel = sz; op_a = a; op_b = b;
    @(posedge clk);
    if (vld) model(op, sz, a, b);
    #1;
    compare_all(op, vld);
  endtask

  task automatic chain96(input bit sub, input bit [95:0] a, input bit [95:0] b);
    logic [31:0] w0, w1, w2;
    logic [96:0] ref97;
    bit [1:0] p, e;
    p = sub ? 2'd1 : 2'd0;
    e = sub ? 2'd3 : 2'd2;
    step(1, p, 2'd2, a[31:0], b[31:0]);   w0 = result;
    step(1, e, 2'd2, a[63:32], b[63:32]); w1 = result;
    step(1, e, 2'd2, a[95:64], b[95:64]); w2 = result;
    ref97 = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    chk({w2, w1, w0} == ref97[95:0], "R10 chain value", {w2, w1, w0}, ref97[95:0]);
    chk(cc_flags[0] == ref97[96], "R10 chain carry", cc_flags[0], ref97[96]);
    chk(cc_flags[2] == (ref97[95:0] == 0), "R10 chain zero", cc_flags[2], ref97[95:0] == 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(result == 0, "R1 result", result, 0);
    chk(cc_flags == 0, "R1 flags", cc_flags, 0);
    m_x = 0; m_n = 0; m_z = 0; m_v = 0; m_c = 0; m_res = 0;
    @(negedge clk); rst = 1'b0;

    // boundary cases
    step(1, 2'd0, 2'd0, 32'hAAAA_AA7F, 32'h0000_0001); // R8 byte add overflow
    step(1, 2'd1, 2'd0, 32'h1234_5680, 32'h0000_0001); // R8 byte sub overflow
    step(1, 2'd0, 2'd1, 32'h0000_7FFF, 32'h0000_0001); // R8 word
    step(1, 2'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001); // R6 carry, R5 zero
    step(1, 2'd3, 2'd2, 32'h0000_0005, 32'h0000_0005); // R7 X set, a==b
    step(1, 2'd1, 2'd1, 32'h0000_0003, 32'h0000_0004); // R7 borrow
    step(1, 2'd2, 2'd0, 32'h0000_00FF, 32'h0000_0000); // R6 X set, result<=b
    step(0, 2'd1, 2'd2, 32'hDEAD_BEEF, 32'h1234_5678); // R2 hold
    step(0, 2'd0, 2'd0, 32'h0000_0000, 32'h0000_0000); // R2 hold
    step(1, 2'd1, 2'd3, 32'h8000_0000, 32'h0000_0001); // R3 size code 3 = long

    // R10: zero piece must not set Z
    step(1, 2'd0, 2'd2, 32'h0000_0001, 32'h0000_0000);
    step(1, 2'd2, 2'd2, 32'h0000_0000, 32'h0000_0000);

    chain96(0, {$urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
    chain96(1, {$urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
    chain96(1, 96'h1234_5678_9ABC_DEF0_1111_2222, 96'h1234_5678_9ABC_DEF0_1111_2222);
    chain96(0, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 96'h1);
    chain96(1, 96'h0, 96'h1);
    chain96(0, 96'h0000_0001_0000_0000_0000_0000, 96'h0);

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 8) != 0, 2'($urandom), 2'($urandom), $urandom, $urandom);
    end
    for (int i = 0; i < 20; i++) begin
      chain96(i[0], {$urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule